// File: doc/BRIEF.md
# Debug Trigger Match and Chain Unit

This block keeps the settings of ten hardware debug triggers and evaluates all of them in every cycle against the current instruction fetch address, load address and store address. Each trigger belongs to a fixed pair. Each pair is tied to a fixed combination of access kinds. A trigger only looks at the access kind it is bound to. A chained pair reports a hit only when both members match together and agree on when the trap should be taken.

Software-side logic loads one trigger at a time through a single write port. After a write, the match logic works combinationally from the registered settings and the live access inputs. The outputs are a fire bit per trigger, a per-trigger flag saying the trap belongs to the next instruction, and a single hit that collects all fire bits. Downstream logic decides what to do with a hit.

Top module: `dbg_trig_unit`

## Requirements
- R1: After reset no trigger fires, for any access input, until that trigger has been written; `fire_vec`, `fire_timing_vec` and `hit_any` are all zero.
- R2: A write with `cfg_wr_en` high loads the entry numbered by `cfg_wr_idx` on that clock edge and arms it. The new settings govern matching from the following cycle. An index of 10 or above changes nothing.
- R3: Trigger binding by index is 0,1 fetch; 2,3 store; 4,5 load; 6 fetch, 7 store; 8 fetch, 9 load (pair p holds triggers 2p and 2p+1). A trigger compares only its own access address, and only while that access's valid is high.
- R4: Match type 0 fires when the address equals the compare value.
- R5: Match type 1 treats the compare value as an aligned power-of-two region. With t trailing ones in the compare value, the low t+1 address bits are ignored and the remaining bits must be equal. An all-ones value matches every address.
- R6: Match type 2 fires when the address is greater than or equal to the compare value (unsigned). Match type 3 fires when the address is strictly less than it.
- R7: A trigger written with the select bit set never fires, because comparison against data is not supported.
- R8: When the chain bit of the even trigger of a pair is set (pairs 0, 2, 3, 4), both triggers fire only if both match in the same cycle. If only one matches, neither fires.
- R9: A chained pair whose two timing bits differ never fires, even when both triggers match.
- R10: A chain request on the store/store pair (triggers 2, 3) is ignored, so each fires on its own match. The chain bit of an odd trigger has no effect. The action bit has no effect on any output.
- R11: `fire_timing_vec` bit i is high exactly when trigger i fires and its timing bit is 1. `hit_any` is the OR of all bits of `fire_vec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Settings write strobe |
| cfg_wr_idx | input | 4 | Trigger number to write |
| cfg_match_type | input | 2 | 0 equal, 1 aligned region, 2 greater-or-equal, 3 less-than |
| cfg_select | input | 1 | 1 requests data comparison (never matches) |
| cfg_timing | input | 1 | 0 trap at current instruction, 1 at next |
| cfg_action | input | 1 | Action request, not used by firing |
| cfg_chain | input | 1 | Chain request (honoured on even triggers only) |
| cfg_compare | input | 64 | Compare value |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| fetch_pc | input | 64 | Fetch address |
| load_valid | input | 1 | Load address is valid this cycle |
| load_addr | input | 64 | Load address |
| store_valid | input | 1 | Store address is valid this cycle |
| store_addr | input | 64 | Store address |
| fire_vec | output | 10 | Per-trigger fire bits |
| fire_timing_vec | output | 10 | Fire bits of triggers whose trap is for the next instruction |
| hit_any | output | 1 | OR of all fire bits |

## Verification
Some properties are checked in every cycle:
- an unarmed trigger stays silent;
- a write arms its entry on the next cycle;
- fire bits of each access kind appear only while that access is valid;
- the members of a chained pair fire together, and only with equal timing.

Other behaviour can only be shown by the bench's scenarios. This covers the arithmetic of the four match types, the aligned-region mask width and the all-ones case. It also covers the store pair ignoring its chain request, the odd chain bit and the action bit having no effect, and out-of-range writes being dropped. These scenarios are compared against an independent model of the pairs.

// File: rtl/dbg_trig_pkg.sv
// Package: shared types and the fixed pair-to-access binding of the
// debug trigger unit. Assumes addresses and compare values share one width.
package dbg_trig_pkg;

    localparam int unsigned ADDR_W = 64;

    typedef enum logic [1:0] {
        MT_EQ    = 2'd0,
        MT_NAPOT = 2'd1,
        MT_GE    = 2'd2,
        MT_LT    = 2'd3
    } match_kind_e;

    typedef enum logic [1:0] {
        AK_FETCH = 2'd0,
        AK_LOAD  = 2'd1,
        AK_STORE = 2'd2
    } access_kind_e;

    typedef struct packed {
        logic              armed;
        match_kind_e       mtype;
        logic              select;
        logic              timing;
        logic              chain;
        logic [ADDR_W-1:0] cmp;
    } trig_cfg_t;

    // Access kind watched by trigger idx; pattern repeats every five pairs.
    function automatic access_kind_e kind_of_trigger(input int unsigned idx);
        int unsigned pair;
        logic        odd;
        pair = (idx / 2) % 5;
        odd  = idx[0];
        case (pair)
            0:       return AK_FETCH;
            1:       return AK_STORE;
            2:       return AK_LOAD;
            3:       return odd ? AK_STORE : AK_FETCH;
            default: return odd ? AK_LOAD : AK_FETCH;
        endcase
    endfunction

    // The store/store pair may not chain.
    function automatic bit pair_may_chain(input int unsigned pair);
        return (pair % 5) != 1;
    endfunction

endpackage

// File: rtl/dbg_trig_cfg_regs.sv
// Settings storage: one register entry per trigger, loaded by a single
// write port. Assumes at most one write per cycle; reset disarms all.
module dbg_trig_cfg_regs
    import dbg_trig_pkg::*;
#(
    parameter int unsigned NUM_TRIG = 10,
    localparam int unsigned IDX_W   = $clog2(NUM_TRIG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  trig_cfg_t        wr_entry,
    output trig_cfg_t        cfg_q [NUM_TRIG]
);

    for (genvar i = 0; i < NUM_TRIG; i++) begin : g_entry
        // Load entry i when it is addressed, clear it on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[i] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                cfg_q[i] <= wr_entry;
            end
        end
    end

endmodule

// File: rtl/dbg_trig_match.sv
// Single trigger comparator: picks the access it is bound to (KIND) and
// applies the configured match type. Purely combinational.
module dbg_trig_match
    import dbg_trig_pkg::*;
#(
    parameter access_kind_e KIND = AK_FETCH
) (
    input  logic              armed,
    input  logic              select,
    input  match_kind_e       mtype,
    input  logic [ADDR_W-1:0] cmp,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic              load_valid,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              store_valid,
    input  logic [ADDR_W-1:0] store_addr,
    output logic              hit
);

    logic              acc_valid;
    logic [ADDR_W-1:0] acc_addr;
    logic [ADDR_W-1:0] region_mask;
    logic              cmp_ok;

    // Route the bound access to the comparator; others are never seen.
    if (KIND == AK_FETCH) begin : g_fetch
        logic unused_other;
        assign unused_other = ^{load_valid, load_addr, store_valid, store_addr};
        assign acc_valid = fetch_valid;
        assign acc_addr  = fetch_pc;
    end else if (KIND == AK_LOAD) begin : g_load
        logic unused_other;
        assign unused_other = ^{fetch_valid, fetch_pc, store_valid, store_addr};
        assign acc_valid = load_valid;
        assign acc_addr  = load_addr;
    end else begin : g_store
        logic unused_other;
        assign unused_other = ^{fetch_valid, fetch_pc, load_valid, load_addr};
        assign acc_valid = store_valid;
        assign acc_addr  = store_addr;
    end

    // Trailing ones plus the next bit form the ignored low-bit mask.
    assign region_mask = cmp ^ (cmp + ADDR_W'(1));

    // Evaluate the selected comparison.
    always_comb begin
        case (mtype)
            MT_EQ:    cmp_ok = (acc_addr == cmp);
            MT_NAPOT: cmp_ok = ((acc_addr | region_mask) == (cmp | region_mask));
            MT_GE:    cmp_ok = (acc_addr >= cmp);
            default:  cmp_ok = (acc_addr < cmp);
        endcase
    end

    assign hit = armed && !select && acc_valid && cmp_ok;

endmodule

// File: rtl/dbg_trig_pair_combine.sv
// Pair combiner: applies chaining to the raw matches of one trigger pair.
// Assumes the chain request comes from the even member only.
module dbg_trig_pair_combine #(
    parameter bit CAN_CHAIN = 1'b1
) (
    input  logic match_even,
    input  logic match_odd,
    input  logic chain_en,
    input  logic timing_even,
    input  logic timing_odd,
    output logic fire_even,
    output logic fire_odd
);

    if (CAN_CHAIN) begin : g_chain
        logic both_ok;
        // Chained members need two matches and equal timing.
        always_comb begin
            both_ok = match_even && match_odd && (timing_even == timing_odd);
            if (chain_en) begin
                fire_even = both_ok;
                fire_odd  = both_ok;
            end else begin
                fire_even = match_even;
                fire_odd  = match_odd;
            end
        end
    end else begin : g_solo
        logic unused_chain;
        assign unused_chain = ^{chain_en, timing_even, timing_odd};
        assign fire_even    = match_even;
        assign fire_odd     = match_odd;
    end

endmodule

// File: rtl/dbg_trig_unit.sv
// Top of the debug trigger unit: settings storage, one comparator per
// trigger and one combiner per pair. Outputs follow inputs combinationally.
module dbg_trig_unit
    import dbg_trig_pkg::*;
#(
    parameter int unsigned NUM_PAIRS = 5,
    localparam int unsigned NUM_TRIG = 2 * NUM_PAIRS,
    localparam int unsigned IDX_W    = $clog2(NUM_TRIG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr_en,
    input  logic [IDX_W-1:0]    cfg_wr_idx,
    input  logic [1:0]          cfg_match_type,
    input  logic                cfg_select,
    input  logic                cfg_timing,
    input  logic                cfg_action,
    input  logic                cfg_chain,
    input  logic [ADDR_W-1:0]   cfg_compare,
    input  logic                fetch_valid,
    input  logic [ADDR_W-1:0]   fetch_pc,
    input  logic                load_valid,
    input  logic [ADDR_W-1:0]   load_addr,
    input  logic                store_valid,
    input  logic [ADDR_W-1:0]   store_addr,
    output logic [NUM_TRIG-1:0] fire_vec,
    output logic [NUM_TRIG-1:0] fire_timing_vec,
    output logic                hit_any
);

    trig_cfg_t             wr_entry;
    trig_cfg_t             cfg_q [NUM_TRIG];
    logic [NUM_TRIG-1:0]   raw_match;
    logic [NUM_TRIG-1:0]   armed_vec;
    logic [NUM_TRIG-1:0]   timing_vec;
    logic [NUM_TRIG-1:0]   chain_vec;
    logic [NUM_PAIRS-1:0]  unused_odd_chain;
    logic                  unused_action;

    // The action request does not take part in firing.
    assign unused_action = cfg_action;

    // Assemble the entry written on this edge; every write arms it.
    always_comb begin
        wr_entry        = '0;
        wr_entry.armed  = 1'b1;
        wr_entry.mtype  = match_kind_e'(cfg_match_type);
        wr_entry.select = cfg_select;
        wr_entry.timing = cfg_timing;
        wr_entry.chain  = cfg_chain;
        wr_entry.cmp    = cfg_compare;
    end

    dbg_trig_cfg_regs #(.NUM_TRIG(NUM_TRIG)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .wr_idx   (cfg_wr_idx),
        .wr_entry (wr_entry),
        .cfg_q    (cfg_q)
    );

    for (genvar i = 0; i < NUM_TRIG; i++) begin : g_trig
        assign armed_vec[i]  = cfg_q[i].armed;
        assign timing_vec[i] = cfg_q[i].timing;
        assign chain_vec[i]  = cfg_q[i].chain;

        dbg_trig_match #(.KIND(kind_of_trigger(i))) u_match (
            .armed       (cfg_q[i].armed),
            .select      (cfg_q[i].select),
            .mtype       (cfg_q[i].mtype),
            .cmp         (cfg_q[i].cmp),
            .fetch_valid (fetch_valid),
            .fetch_pc    (fetch_pc),
            .load_valid  (load_valid),
            .load_addr   (load_addr),
            .store_valid (store_valid),
            .store_addr  (store_addr),
            .hit         (raw_match[i])
        );
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        assign unused_odd_chain[p] = chain_vec[2*p+1];

        dbg_trig_pair_combine #(.CAN_CHAIN(pair_may_chain(p))) u_pair (
            .match_even  (raw_match[2*p]),
            .match_odd   (raw_match[2*p+1]),
            .chain_en    (chain_vec[2*p]),
            .timing_even (timing_vec[2*p]),
            .timing_odd  (timing_vec[2*p+1]),
            .fire_even   (fire_vec[2*p]),
            .fire_odd    (fire_vec[2*p+1])
        );
    end

    assign fire_timing_vec = fire_vec & timing_vec;
    assign hit_any         = |fire_vec;

endmodule

// File: rtl/dbg_trig_unit_checker.sv
// Checker for dbg_trig_unit: per-cycle properties on arming, access
// qualification and chaining. Attached by the bind below.
module dbg_trig_unit_checker
    import dbg_trig_pkg::*;
#(
    parameter int unsigned NUM_TRIG = 10,
    localparam int unsigned IDX_W   = $clog2(NUM_TRIG)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_wr_en,
    input logic [IDX_W-1:0]    cfg_wr_idx,
    input logic                fetch_valid,
    input logic                load_valid,
    input logic                store_valid,
    input logic [NUM_TRIG-1:0] fire_vec,
    input logic [NUM_TRIG-1:0] armed_vec,
    input logic [NUM_TRIG-1:0] timing_vec,
    input logic [NUM_TRIG-1:0] chain_vec
);

    logic [NUM_TRIG-1:0] fetch_mask;
    logic [NUM_TRIG-1:0] load_mask;
    logic [NUM_TRIG-1:0] store_mask;

    for (genvar i = 0; i < NUM_TRIG; i++) begin : g_each
        assign fetch_mask[i] = (kind_of_trigger(i) == AK_FETCH);
        assign load_mask[i]  = (kind_of_trigger(i) == AK_LOAD);
        assign store_mask[i] = (kind_of_trigger(i) == AK_STORE);

        assert_unarmed_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
            !armed_vec[i] |-> !fire_vec[i]);
    end

    assert_write_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && (int'(cfg_wr_idx) < NUM_TRIG)) |=> armed_vec[$past(cfg_wr_idx)]);

    assert_fetch_qualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((fire_vec & fetch_mask) != '0) |-> fetch_valid);

    assert_load_qualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((fire_vec & load_mask) != '0) |-> load_valid);

    assert_store_qualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((fire_vec & store_mask) != '0) |-> store_valid);

    for (genvar p = 0; p < NUM_TRIG / 2; p++) begin : g_pairs
        if (pair_may_chain(p)) begin : g_chk
            assert_chain_together_R8: assert property (@(posedge clk) disable iff (!rst_n)
                chain_vec[2*p] |-> (fire_vec[2*p] == fire_vec[2*p+1]));

            assert_chain_timing_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (chain_vec[2*p] && fire_vec[2*p]) |-> (timing_vec[2*p] == timing_vec[2*p+1]));
        end
    end

endmodule

bind dbg_trig_unit dbg_trig_unit_checker #(.NUM_TRIG(NUM_TRIG)) i_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_idx  (cfg_wr_idx),
    .fetch_valid (fetch_valid),
    .load_valid  (load_valid),
    .store_valid (store_valid),
    .fire_vec    (fire_vec),
    .armed_vec   (armed_vec),
    .timing_vec  (timing_vec),
    .chain_vec   (chain_vec)
);

// File: tb/test_dbg_trig_unit.sv
// Bench: directed corner cases plus seeded random traffic, checked
// against an independent model of the ten triggers.
module test_dbg_trig_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NT = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [3:0]  cfg_wr_idx = '0;
    logic [1:0]  cfg_match_type = '0;
    logic        cfg_select = 1'b0;
    logic        cfg_timing = 1'b0;
    logic        cfg_action = 1'b0;
    logic        cfg_chain = 1'b0;
    logic [63:0] cfg_compare = '0;
    logic        fetch_valid = 1'b0;
    logic [63:0] fetch_pc = '0;
    logic        load_valid = 1'b0;
    logic [63:0] load_addr = '0;
    logic        store_valid = 1'b0;
    logic [63:0] store_addr = '0;
    logic [NT-1:0] fire_vec;
    logic [NT-1:0] fire_timing_vec;
    logic          hit_any;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Bench model of the written settings.
    logic        m_armed [NT];
    logic [1:0]  m_type  [NT];
    logic        m_sel   [NT];
    logic        m_tim   [NT];
    logic        m_chain [NT];
    logic [63:0] m_cmp   [NT];

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_trig_unit i_dbg_trig_unit (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx),
        .cfg_match_type(cfg_match_type), .cfg_select(cfg_select), .cfg_timing(cfg_timing),
        .cfg_action(cfg_action), .cfg_chain(cfg_chain), .cfg_compare(cfg_compare),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .load_valid(load_valid),
        .load_addr(load_addr), .store_valid(store_valid), .store_addr(store_addr),
        .fire_vec(fire_vec), .fire_timing_vec(fire_timing_vec), .hit_any(hit_any)
    );

    // 0 fetch, 1 load, 2 store, per the R3 binding.
    function automatic int bench_kind(input int i);
        case (i)
            0, 1, 6, 8: return 0;
            4, 5, 9:    return 1;
            default:    return 2;
        endcase
    endfunction

    function automatic logic bench_raw(input int i);
        logic        v;
        logic [63:0] a;
        int          t;
        int          k;
        k = bench_kind(i);
        v = (k == 0) ? fetch_valid : (k == 1) ? load_valid : store_valid;
        a = (k == 0) ? fetch_pc : (k == 1) ? load_addr : store_addr;
        if (!m_armed[i] || m_sel[i] || !v) return 1'b0;
        case (m_type[i])
            2'd0: return a == m_cmp[i];
            2'd1: begin
                t = 0;
                while (t < 64 && m_cmp[i][t]) t++;
                if (t >= 63) return 1'b1;
                return (a >> (t + 1)) == (m_cmp[i] >> (t + 1));
            end
            2'd2: return a >= m_cmp[i];
            default: return a < m_cmp[i];
        endcase
    endfunction

    function automatic logic [NT-1:0] bench_fire();
        logic [NT-1:0] f;
        logic re, ro, both;
        f = '0;
        for (int p = 0; p < NT/2; p++) begin
            re = bench_raw(2*p);
            ro = bench_raw(2*p+1);
            if (p != 1 && m_chain[2*p]) begin
                both = re && ro && (m_tim[2*p] == m_tim[2*p+1]);
                f[2*p] = both;
                f[2*p+1] = both;
            end else begin
                f[2*p] = re;
                f[2*p+1] = ro;
            end
        end
        return f;
    endfunction

    task automatic write_trig(input int idx, input logic [1:0] mt, input logic sel,
                              input logic tim, input logic act, input logic ch,
                              input logic [63:0] cmp);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_idx = 4'(idx); cfg_match_type = mt; cfg_select = sel;
        cfg_timing = tim; cfg_action = act; cfg_chain = ch; cfg_compare = cmp;
        if (idx < NT) begin
            m_armed[idx] = 1'b1; m_type[idx] = mt; m_sel[idx] = sel;
            m_tim[idx] = tim; m_chain[idx] = ch; m_cmp[idx] = cmp;
        end
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic probe(input logic fv, input logic [63:0] fa, input logic lv,
                         input logic [63:0] la, input logic sv, input logic [63:0] sa,
                         input string tag);
        logic [NT-1:0] ef, et;
        @(negedge clk);
        fetch_valid = fv; fetch_pc = fa; load_valid = lv; load_addr = la;
        store_valid = sv; store_addr = sa;
        #1;
        ef = bench_fire();
        et = '0;
        for (int i = 0; i < NT; i++) et[i] = ef[i] && m_tim[i];
        n_cmp++;
        if (fire_vec !== ef || fire_timing_vec !== et || hit_any !== (|ef)) begin
            n_bad++;
            $display("FAIL %s: fire=%b timing=%b hit=%b expected fire=%b timing=%b hit=%b",
                     tag, fire_vec, fire_timing_vec, hit_any, ef, et, |ef);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NT; i++) begin
            m_armed[i] = 0; m_type[i] = 0; m_sel[i] = 0;
            m_tim[i] = 0; m_chain[i] = 0; m_cmp[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: nothing armed, zero addresses everywhere
        probe(1, 64'h0, 1, 64'h0, 1, 64'h0, "R1 reset state");

        // R4: trigger 0 fetch equality
        write_trig(0, 2'd0, 0, 0, 0, 0, 64'h1000);
        probe(1, 64'h1000, 0, 0, 0, 0, "R4 equal hit");
        probe(1, 64'h1004, 0, 0, 0, 0, "R4 equal miss");
        // R3: invalid fetch, and fetch trigger blind to load/store
        probe(0, 64'h1000, 0, 0, 0, 0, "R3 fetch not valid");
        probe(1, 64'h2000, 1, 64'h1000, 1, 64'h1000, "R3 other kinds ignored");

        // R2: out-of-range index changes nothing
        write_trig(12, 2'd2, 0, 0, 0, 0, 64'h0);
        probe(1, 64'h55, 1, 64'h55, 1, 64'h55, "R2 out of range write");

        // R5: store trigger 2 aligned region, 3 trailing ones -> 16 bytes
        write_trig(2, 2'd1, 0, 0, 0, 0, 64'h2007);
        probe(0, 0, 0, 0, 1, 64'h200C, "R5 region inside");
        probe(0, 0, 0, 0, 1, 64'h2010, "R5 region outside");
        write_trig(3, 2'd1, 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        probe(0, 0, 0, 0, 1, 64'h1234_5678, "R5 all ones matches all");

        // R6: load triggers 4 (>=) and 5 (<)
        write_trig(4, 2'd2, 0, 0, 0, 0, 64'h500);
        write_trig(5, 2'd3, 0, 1, 0, 0, 64'h500);
        probe(0, 0, 1, 64'h500, 0, 0, "R6 ge boundary");
        probe(0, 0, 1, 64'h4FF, 0, 0, "R6 lt boundary");

        // R7: select set never fires
        write_trig(1, 2'd0, 1, 0, 0, 0, 64'h1000);
        probe(1, 64'h1000, 0, 0, 0, 0, "R7 select set");

        // R8/R9: pair 3 chained (fetch 6, store 7)
        write_trig(6, 2'd0, 0, 0, 0, 1, 64'h3000);
        write_trig(7, 2'd0, 0, 0, 0, 0, 64'h4000);
        probe(1, 64'h3000, 0, 0, 0, 0, "R8 one of chained pair");
        probe(1, 64'h3000, 0, 0, 1, 64'h4000, "R8 both of chained pair");
        write_trig(7, 2'd0, 0, 1, 0, 0, 64'h4000);
        probe(1, 64'h3000, 0, 0, 1, 64'h4000, "R9 timing differs");

        // R10: store pair chain ignored; odd chain ignored; action ignored
        write_trig(2, 2'd1, 0, 0, 1, 1, 64'h2007);
        write_trig(3, 2'd0, 0, 0, 0, 0, 64'h6000);
        probe(0, 0, 0, 0, 1, 64'h200C, "R10 store pair unchained");
        write_trig(8, 2'd0, 0, 1, 1, 0, 64'h8000);
        write_trig(9, 2'd0, 0, 0, 0, 1, 64'h7000);
        probe(0, 0, 1, 64'h7000, 0, 0, "R10 odd chain bit");

        // R11: timing indication on trigger 8
        probe(1, 64'h8000, 1, 64'h7000, 0, 0, "R11 timing and hit");

        // Random traffic over a small address space (R2..R11)
        for (int n = 0; n < 400; n++) begin
            if (($urandom % 3) == 0)
                write_trig(int'($urandom % 11), 2'($urandom), ($urandom % 6) == 0,
                           1'($urandom), 1'($urandom), 1'($urandom),
                           64'($urandom % 256));
            probe(1'($urandom), 64'($urandom % 256), 1'($urandom), 64'($urandom % 256),
                  1'($urandom), 64'($urandom % 256), "R3-R11 random");
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule